// File: doc/BRIEF.md
# Way-Predicted Two-Way Read Cache

This block is a two-way set-associative read cache with 64-byte lines. Each set holds a way-prediction bit. On a lookup the cache compares only the predicted way in the first cycle. If the predicted way holds the line, the word is returned one cycle after the request is accepted. If the other way holds the line, the cache answers one cycle later, flags the late answer on `resp_slow`, and retrains the prediction bit to point at the way that hit. If neither way holds the line, the cache asks the next level for the whole line on a refill port. The victim way is chosen by a per-set LRU bit, and the answer follows the refill.

A per-request `way_sel_mode` input turns on an energy-saving variant. In that variant the first lookup cycle enables only the data array of the predicted way, instead of both. The `way_en` output shows which data arrays are enabled in every cycle, so the saving can be seen at the port. Addresses are word addresses with 32-bit words. Only one request is in flight at a time, and a request is taken only while `req_ready` is high.

Top module: `wp_cache`

## Requirements
- R1: After reset, `req_ready` is 1 and `resp_valid`, `resp_slow`, `refill_req` and `way_en` are 0. All lines are invalid and every prediction and LRU bit is 0, so the first access to any address misses and fills way 0.
- R2: A lookup whose predicted way holds the tag gives `resp_valid` exactly one cycle after acceptance, with `resp_slow` at 0.
- R3: A lookup whose predicted way misses while the other way holds the tag gives `resp_valid` exactly two cycles after acceptance. `resp_slow` is 1 in that same cycle only.
- R4: After a slow hit, the prediction bit of that set points at the way that hit. The next access to the same line is a one-cycle hit.
- R5: A miss in both ways raises `refill_req` three cycles after acceptance, with `refill_addr` equal to the line number (word address bits [13:4]). The request is held until `refill_valid`. `resp_valid` follows in the cycle after `refill_valid` is taken.
- R6: On a miss the victim is the way named by the set's LRU bit. Any hit or fill makes the other way the LRU way.
- R7: After a refill, the prediction bit of that set points at the filled way. An immediate re-access is a one-cycle hit.
- R8: `way_en` (bit 0 = way 0) is 2'b11 in the first lookup cycle when the request's `way_sel_mode` was 0. It is the one-hot of the predicted way when `way_sel_mode` was 1. It is the one-hot of the other way in the second lookup cycle, the one-hot of the filled way in the fill answer cycle, and 0 otherwise.
- R9: `resp_data` is word `req_addr[3:0]` of the line, where word i is held in bits [32*i+31:32*i] of `refill_data`.
- R10: `req_ready` is 1 only while no request is in flight. It is 0 in the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 14 | Word address: tag [13:7], set [6:4], word [3:0] |
| way_sel_mode | input | 1 | Enable only the predicted data array in the first cycle |
| req_ready | output | 1 | Cache idle, request accepted on this edge |
| resp_valid | output | 1 | Response word valid |
| resp_data | output | 32 | Response word |
| resp_slow | output | 1 | Response came from the non-predicted way |
| way_en | output | 2 | Data array enables, one bit per way |
| refill_req | output | 1 | Line fetch request to next level |
| refill_addr | output | 10 | Line number to fetch |
| refill_valid | input | 1 | Fetched line present on refill_data |
| refill_data | input | 512 | Fetched line, word 0 in low bits |

## Verification
Counted from the edge that accepts a request, a predicted-way hit answers after one cycle and a non-predicted-way hit after two. A miss raises its fetch after three cycles and answers one cycle after the fetched line is taken, which is four cycles when the bench returns the line at once. The bench drives inputs and samples on falling edges. It counts those edges from acceptance to the response, and holds a model of tags, prediction and LRU bits to predict which of the three latencies applies. The array enables are sampled in the first lookup cycle and again in the response cycle, where each rule in R8 names its expected value.

// File: rtl/wp_pkg.sv
// Package: shared constants and the controller state type for the
// way-predicted cache. Assumes two ways; the associativity is not a knob.
package wp_pkg;
    localparam int WAYS = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROBE_PRED,
        ST_PROBE_ALT,
        ST_FETCH,
        ST_FILL_RESP
    } wp_state_e;
endpackage

// File: rtl/wp_tag_store.sv
// Tag store: one valid bit and one tag per set per way, with a hit vector
// for the looked-up set. Assumes a single write port used only on refill.
module wp_tag_store #(
    parameter int SETS  = 8,
    parameter int IDX_W = 3,
    parameter int TAG_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] cmp_tag,
    input  logic             wr_en,
    input  logic             wr_way,
    output logic [1:0]       way_hit
);
    for (genvar w = 0; w < wp_pkg::WAYS; w++) begin : g_way
        localparam logic WAY_ID = 1'(w);
        logic [SETS-1:0]  vld_q;
        logic [TAG_W-1:0] tag_q [SETS];

        // Valid bits: cleared by reset, set when this way is filled.
        always_ff @(posedge clk) begin
            if (!rst_n)
                vld_q <= '0;
            else if (wr_en && wr_way == WAY_ID)
                vld_q[idx] <= 1'b1;
        end

        // Tags: written with the lookup tag on a fill of this way.
        always_ff @(posedge clk) begin
            if (wr_en && wr_way == WAY_ID)
                tag_q[idx] <= cmp_tag;
        end

        assign way_hit[w] = vld_q[idx] && (tag_q[idx] == cmp_tag);
    end
endmodule

// File: rtl/wp_data_store.sv
// Data store: one line array per way; each way drives its selected word
// only when enabled, otherwise zero, modelling a gated array.
// Assumes whole-line writes from the refill port.
module wp_data_store #(
    parameter int SETS   = 8,
    parameter int IDX_W  = 3,
    parameter int WORDS  = 16,
    parameter int WSEL_W = 4,
    parameter int WORD_W = 32
) (
    input  logic                          clk,
    input  logic [IDX_W-1:0]              idx,
    input  logic [WSEL_W-1:0]             wsel,
    input  logic [1:0]                    rd_en,
    input  logic                          wr_en,
    input  logic                          wr_way,
    input  logic [WORDS-1:0][WORD_W-1:0]  wr_line,
    output logic [1:0][WORD_W-1:0]        rd_word
);
    for (genvar w = 0; w < wp_pkg::WAYS; w++) begin : g_way
        localparam logic WAY_ID = 1'(w);
        logic [WORDS-1:0][WORD_W-1:0] line_q [SETS];

        // Line write on refill of this way.
        always_ff @(posedge clk) begin
            if (wr_en && wr_way == WAY_ID)
                line_q[idx] <= wr_line;
        end

        // Word read, gated by the array enable.
        always_comb begin
            rd_word[w] = rd_en[w] ? line_q[idx][wsel] : '0;
        end
    end
endmodule

// File: rtl/wp_way_state.sv
// Per-set prediction and LRU bits. The prediction bit names the way probed
// first; the LRU bit names the next victim. Both reset to zero.
module wp_way_state #(
    parameter int SETS  = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             pred_we,
    input  logic             pred_d,
    input  logic             lru_we,
    input  logic             lru_d,
    output logic             pred_o,
    output logic             lru_o
);
    logic [SETS-1:0] pred_q;
    logic [SETS-1:0] lru_q;

    // Prediction bits: retrained on slow hits and fills.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pred_q <= '0;
        else if (pred_we)
            pred_q[idx] <= pred_d;
    end

    // LRU bits: point away from the way last used.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lru_q <= '0;
        else if (lru_we)
            lru_q[idx] <= lru_d;
    end

    assign pred_o = pred_q[idx];
    assign lru_o  = lru_q[idx];
endmodule

// File: rtl/wp_cache.sv
// Top: way-predicted two-way read cache. Accepts one request while idle,
// probes the predicted way, then the other way, then fetches the line.
// Assumes the next level answers refill_req eventually with a whole line.
module wp_cache #(
    parameter int ADDR_W      = 14,
    parameter int WORD_W      = 32,
    parameter int BLOCK_BYTES = 64,
    parameter int SETS        = 8,
    localparam int WORDS      = BLOCK_BYTES * 8 / WORD_W,
    localparam int WSEL_W     = $clog2(WORDS),
    localparam int IDX_W      = $clog2(SETS),
    localparam int TAG_W      = ADDR_W - WSEL_W - IDX_W,
    localparam int LINE_W     = ADDR_W - WSEL_W,
    localparam int BLOCK_BITS = BLOCK_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic                  way_sel_mode,
    output logic                  req_ready,
    output logic                  resp_valid,
    output logic [WORD_W-1:0]     resp_data,
    output logic                  resp_slow,
    output logic [1:0]            way_en,
    output logic                  refill_req,
    output logic [LINE_W-1:0]     refill_addr,
    input  logic                  refill_valid,
    input  logic [BLOCK_BITS-1:0] refill_data
);
    import wp_pkg::*;

    wp_state_e         state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              mode_q;
    logic              victim_q;

    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    logic [WSEL_W-1:0] wsel;
    logic [1:0]        way_hit;
    logic [1:0][WORD_W-1:0] rd_word;
    logic              pred, lru, alt;
    logic              fast_hit, slow_hit, fill_now;
    logic              pred_we, pred_d, lru_we, lru_d;
    logic              resp_way;

    assign idx  = addr_q[WSEL_W +: IDX_W];
    assign tag  = addr_q[ADDR_W-1 -: TAG_W];
    assign wsel = addr_q[WSEL_W-1:0];
    assign alt  = ~pred;

    assign fast_hit = (state_q == ST_PROBE_PRED) && way_hit[pred];
    assign slow_hit = (state_q == ST_PROBE_ALT)  && way_hit[alt];
    assign fill_now = (state_q == ST_FETCH)      && refill_valid;

    wp_tag_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (idx),
        .cmp_tag (tag),
        .wr_en   (fill_now),
        .wr_way  (victim_q),
        .way_hit (way_hit)
    );

    wp_data_store #(
        .SETS(SETS), .IDX_W(IDX_W), .WORDS(WORDS),
        .WSEL_W(WSEL_W), .WORD_W(WORD_W)
    ) u_data (
        .clk     (clk),
        .idx     (idx),
        .wsel    (wsel),
        .rd_en   (way_en),
        .wr_en   (fill_now),
        .wr_way  (victim_q),
        .wr_line (refill_data),
        .rd_word (rd_word)
    );

    wp_way_state #(.SETS(SETS), .IDX_W(IDX_W)) u_ways (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (idx),
        .pred_we (pred_we),
        .pred_d  (pred_d),
        .lru_we  (lru_we),
        .lru_d   (lru_d),
        .pred_o  (pred),
        .lru_o   (lru)
    );

    // Predictor and LRU update rules for hits and fills.
    always_comb begin
        pred_we = slow_hit || fill_now;
        pred_d  = fill_now ? victim_q : alt;
        lru_we  = fast_hit || slow_hit || fill_now;
        if (fill_now)
            lru_d = ~victim_q;
        else if (slow_hit)
            lru_d = pred;
        else
            lru_d = alt;
    end

    // Data array enables for the current cycle.
    always_comb begin
        way_en = 2'b00;
        unique case (state_q)
            ST_PROBE_PRED: way_en = mode_q ? (pred ? 2'b10 : 2'b01) : 2'b11;
            ST_PROBE_ALT:  way_en = alt ? 2'b10 : 2'b01;
            ST_FILL_RESP:  way_en = victim_q ? 2'b10 : 2'b01;
            default:       way_en = 2'b00;
        endcase
    end

    // Response way select and response outputs.
    always_comb begin
        unique case (state_q)
            ST_PROBE_ALT: resp_way = alt;
            ST_FILL_RESP: resp_way = victim_q;
            default:      resp_way = pred;
        endcase
        resp_valid = fast_hit || slow_hit || (state_q == ST_FILL_RESP);
        resp_slow  = slow_hit;
        resp_data  = rd_word[resp_way];
    end

    assign req_ready   = (state_q == ST_IDLE);
    assign refill_req  = (state_q == ST_FETCH);
    assign refill_addr = addr_q[ADDR_W-1:WSEL_W];

    // Next-state logic of the lookup sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (req_valid) state_d = ST_PROBE_PRED;
            ST_PROBE_PRED: state_d = fast_hit ? ST_IDLE : ST_PROBE_ALT;
            ST_PROBE_ALT:  state_d = slow_hit ? ST_IDLE : ST_FETCH;
            ST_FETCH:      if (refill_valid) state_d = ST_FILL_RESP;
            ST_FILL_RESP:  state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Request capture on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            mode_q <= 1'b0;
        end else if (state_q == ST_IDLE && req_valid) begin
            addr_q <= req_addr;
            mode_q <= way_sel_mode;
        end
    end

    // Victim choice taken from the LRU bit once both ways have missed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            victim_q <= 1'b0;
        else if (state_q == ST_PROBE_ALT && !slow_hit)
            victim_q <= lru;
    end
endmodule

// File: rtl/wp_cache_chk.sv
// Checker: protocol and timing properties of the way-predicted cache,
// bound to every wp_cache instance.
module wp_cache_chk #(
    parameter int LINE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              resp_slow,
    input logic [1:0]        way_en,
    input logic              refill_req,
    input logic [LINE_W-1:0] refill_addr,
    input logic              refill_valid,
    input logic              first_probe,
    input logic              sel_mode
);
    // R3
    slow_flag_with_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_slow |-> resp_valid);

    // R3
    slow_flag_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_slow |=> !resp_slow);

    // R5
    refill_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_req && !refill_valid) |=> (refill_req && $stable(refill_addr)));

    // R5
    fill_then_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_req && refill_valid) |=> resp_valid);

    // R10
    busy_on_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_ready);

    // R8
    one_array_in_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (first_probe && sel_mode) |-> ($countones(way_en) == 1));

    // R8
    arrays_off_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready || refill_req) |-> (way_en == 2'b00));
endmodule

bind wp_cache wp_cache_chk #(.LINE_W(LINE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .resp_valid   (resp_valid),
    .resp_slow    (resp_slow),
    .way_en       (way_en),
    .refill_req   (refill_req),
    .refill_addr  (refill_addr),
    .refill_valid (refill_valid),
    .first_probe  (state_q == wp_pkg::ST_PROBE_PRED),
    .sel_mode     (mode_q)
);

// File: tb/wp_cache_bench.sv
// Bench: sweeps every set through miss, fast-hit, slow-hit and eviction
// patterns, then every word of a line, against a model of tags,
// prediction and LRU bits.
module wp_cache_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [13:0]  req_addr = '0;
    logic         way_sel_mode = 1'b0;
    logic         req_ready, resp_valid, resp_slow, refill_req;
    logic [31:0]  resp_data;
    logic [1:0]   way_en;
    logic [9:0]   refill_addr;
    logic         refill_valid = 1'b0;
    logic [511:0] refill_data = '0;

    int checks = 0;
    int fails  = 0;

    // model state
    logic [6:0] m_tag [2][8];
    logic       m_val [2][8];
    logic       m_pred [8];
    logic       m_lru  [8];

    always #5 clk = ~clk;

    wp_cache u_wp_cache (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .way_sel_mode(way_sel_mode), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_data(resp_data), .resp_slow(resp_slow),
        .way_en(way_en), .refill_req(refill_req), .refill_addr(refill_addr),
        .refill_valid(refill_valid), .refill_data(refill_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input logic [9:0] line, input int i);
        return {6'h2A, line, 12'h000, 4'(i)};
    endfunction

    function automatic logic [511:0] line_of(input logic [9:0] line);
        logic [511:0] r;
        for (int i = 0; i < 16; i++) r[32*i +: 32] = word_of(line, i);
        return r;
    endfunction

    function automatic logic [1:0] hot(input logic w);
        return w ? 2'b10 : 2'b01;
    endfunction

    // One access: predicts fast (1), slow (2) or miss (4 cycles) from the model.
    task automatic access(input logic [6:0] t, input logic [2:0] s,
                          input logic [3:0] wd, input logic sm);
        logic [13:0] a = {t, s, wd};
        logic p = m_pred[s];
        int cls, exp_lat, n;
        logic [1:0] en_first, exp_resp_en;
        logic victim = m_lru[s];
        bit saw_fill = 0;
        if (m_val[p][s] && m_tag[p][s] == t) cls = 0;
        else if (m_val[~p][s] && m_tag[~p][s] == t) cls = 1;
        else cls = 2;
        exp_lat = (cls == 0) ? 1 : (cls == 1) ? 2 : 4;

        @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready when idle", 32'(req_ready), 1);
        req_valid = 1'b1; req_addr = a; way_sel_mode = sm;
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        en_first = way_en;
        while (!resp_valid && n < 20) begin
            if (refill_req && !refill_valid) begin
                saw_fill = 1;
                chk(refill_addr == a[13:4], "R5 refill line address",
                    32'(refill_addr), 32'(a[13:4]));
                refill_data  = line_of(a[13:4]);
                refill_valid = 1'b1;
            end else begin
                refill_valid = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        refill_valid = 1'b0;

        // R2 R3 R5 latency per class
        chk(n == exp_lat, cls == 0 ? "R2 fast latency" : cls == 1 ? "R3 slow latency"
            : "R5 miss latency", 32'(n), 32'(exp_lat));
        chk(resp_slow == (cls == 1), "R3 slow flag", 32'(resp_slow), 32'(cls == 1));
        chk(saw_fill == (cls == 2), "R5 refill only on miss", 32'(saw_fill), 32'(cls == 2));
        chk(resp_data == word_of(a[13:4], int'(wd)), "R9 data word",
            resp_data, word_of(a[13:4], int'(wd)));
        chk(req_ready == 1'b0, "R10 busy in response cycle", 32'(req_ready), 0);
        chk(en_first == (sm ? hot(p) : 2'b11), "R8 first-cycle enables",
            32'(en_first), 32'(sm ? hot(p) : 2'b11));
        exp_resp_en = (cls == 0) ? (sm ? hot(p) : 2'b11) : (cls == 1) ? hot(~p) : hot(victim);
        chk(way_en == exp_resp_en, "R8 response-cycle enables", 32'(way_en), 32'(exp_resp_en));

        // model update: R4 R6 R7
        if (cls == 0) m_lru[s] = ~p;
        else if (cls == 1) begin m_pred[s] = ~p; m_lru[s] = p; end
        else begin
            m_tag[victim][s] = t; m_val[victim][s] = 1'b1;
            m_pred[s] = victim; m_lru[s] = ~victim;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1500000;
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int w = 0; w < 2; w++)
            for (int s = 0; s < 8; s++) begin m_val[w][s] = 0; m_tag[w][s] = '0; end
        for (int s = 0; s < 8; s++) begin m_pred[s] = 0; m_lru[s] = 0; end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 1);
        chk(resp_valid == 1'b0, "R1 no response after reset", 32'(resp_valid), 0);
        chk(resp_slow == 1'b0, "R1 no slow flag after reset", 32'(resp_slow), 0);
        chk(refill_req == 1'b0, "R1 no refill after reset", 32'(refill_req), 0);
        chk(way_en == 2'b00, "R1 arrays off after reset", 32'(way_en), 0);

        // Per-set sweep: R1 first miss, R7 fill retrain, R3/R4 slow and retrain, R6 eviction
        for (int s = 0; s < 8; s++) begin
            logic [6:0] ta = 7'(s + 1);
            logic [6:0] tb = 7'(s + 9);
            logic [6:0] tc = 7'(s + 33);
            logic sm = s[0];
            access(ta, 3'(s), 4'd0, sm);   // miss -> way0
            access(ta, 3'(s), 4'd1, ~sm);  // fast
            access(tb, 3'(s), 4'd2, sm);   // miss -> way1
            access(ta, 3'(s), 4'd3, sm);   // slow
            access(ta, 3'(s), 4'd4, ~sm);  // fast after retrain
            access(tb, 3'(s), 4'd5, sm);   // slow
            access(tc, 3'(s), 4'd6, ~sm);  // miss, evicts LRU way0
            access(tb, 3'(s), 4'd7, sm);   // slow
            access(ta, 3'(s), 4'd8, ~sm);  // miss, ta was evicted
            access(ta, 3'(s), 4'd9, sm);   // fast
        end

        // Every word of one line, both modes: R9 R2
        for (int w = 0; w < 16; w++)
            access(7'd1, 3'd0, 4'(w), w[0]);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule